// File: doc/BRIEF.md
# Cyclic Carry Normalisation Unit

This unit turns the coefficient polynomial that a lattice decryption step produces into a binary plaintext word. The polynomial is read as a number: the value at X = 2 of a polynomial with N non-negative coefficients. The unit rewrites it as N binary digits, and that value stays fixed modulo 2^N − 1. Because 2^N is congruent to 1 under that modulus, the carry that leaves the top coefficient returns to position 0.

The coefficients enter one per cycle while the select input is high. Index 0 enters first. They sit in a circular shift ring that is N entries deep and CW bits wide. A start pulse with select low then runs the ring through exactly two full turns (2N cycles). Each cycle handles the entry at the head of the ring. It adds the running carry, writes the low bit back at the tail, and keeps the rest as the next carry. The first turn leaves only binary digits, apart from a carry that has wrapped around. The second turn absorbs most of that carry. Any single carry that is still left is folded into the N-bit output by an incrementer.

Top module: `ccn_unit`

## Requirements
- R1: After reset, busy and done are low and plain is all zeros.
- R2: While busy is low, a cycle with sel = 1 and in_valid = 1 shifts in_coef into the ring. The N most recent such loads form the polynomial, and the earliest of them is coefficient 0. Loaded values must be below 2^(CW−1).
- R3: A cycle with sel = 0, start = 1 and busy low starts a run. busy is high for exactly 2N cycles. done rises in the cycle in which busy falls.
- R4: When done is high, plain read as an N-bit integer is congruent to the sum of coefficient i times 2^i, modulo 2^N − 1.
- R5: If every loaded coefficient is 0 or 1, the run leaves those digits unchanged, and plain bit i equals coefficient i.
- R6: A load or a start arriving while busy is high has no effect. done stays high until the next accepted load or start, and either one clears it.
- R7: All N coefficients at the largest allowed value, 2^(CW−1) − 1, give the correct residue with no internal overflow.
- R8: The carry out of coefficient N−1 goes into coefficient 0. If only coefficient N−1 is loaded, with value 2, plain = 1.
- R9: While idle, start with sel = 1 does not start a run. in_valid with sel = 0 does not load, and the ring keeps its contents.
- R10: A carry still left after the second turn is folded into plain without loss. Coefficients 0..N−2 equal to 1 and coefficient N−1 equal to 3 give plain = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | 1 selects loading, 0 selects normalisation |
| in_valid | input | 1 | Qualifies in_coef during loading |
| in_coef | input | CW | Incoming coefficient |
| start | input | 1 | Starts a run when sel is 0 and the unit is idle |
| busy | output | 1 | High during the 2N normalisation cycles |
| done | output | 1 | plain holds a valid result |
| plain | output | N | Binary plaintext, bit i has weight 2^i |

## Verification
The bench builds the unit with N = 13 and CW = 7. This keeps a run to 26 cycles, so both turns, the wrap of the carry into position 0 and the fold of a leftover carry all happen many times within a short run. With N = 13 the whole polynomial value fits in a 64-bit integer. The bench can therefore compute the exact residue modulo 8191 for random inputs and for the largest-value input. These parameter values also make it cheap to produce the rare pattern that leaves a carry after the second turn.

// File: rtl/ccn_unit.sv
module ccn_unit #(
  parameter int N  = 251,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          in_valid,
  input  logic [CW-1:0] in_coef,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [N-1:0]  plain
);
  localparam int CNTW = $clog2(2*N+1);
  localparam int CARW = CW-1;
  localparam logic [CNTW-1:0] LAST = CNTW'(2*N-1);

  logic [CW-1:0]   ring [N];
  logic [CARW-1:0] carry;
  logic [CNTW-1:0] cnt;
  logic [CW:0]     sum_w;
  logic [CW-1:0]   wb;
  logic [N-1:0]    digits;

  assign sum_w = {1'b0, ring[0]} + (CW+1)'(carry);
  assign wb    = {{(CW-1){1'b0}}, sum_w[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ring[i] <= '0;
      carry <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else if (busy) begin
      for (int i = 0; i < N-1; i++) ring[i] <= ring[i+1];
      ring[N-1] <= wb;
      carry <= sum_w[CW-1:1];
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else if (start && !sel) begin
      busy  <= 1'b1;
      cnt   <= '0;
      carry <= '0;
      done  <= 1'b0;
    end else if (sel && in_valid) begin
      for (int i = 0; i < N-1; i++) ring[i] <= ring[i+1];
      ring[N-1] <= in_coef;
      done <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dig
    assign digits[g] = ring[g][0];
  end

  assign plain = digits + N'(carry);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) busy |-> sum_w[CW] == 1'b0); // R7
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cnt <= LAST); // R3
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R3
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done); // R6
  AST_RESIDUAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> carry <= CARW'(1)); // R4
  AST_NO_WRAP_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (done && carry != '0) |-> ring[N-1][0] == 1'b0); // R10
  AST_INPUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (sel && in_valid && !busy) |-> in_coef[CW-1] == 1'b0); // R2
endmodule

// File: tb/ccn_unit_tb.sv
module ccn_unit_tb_top;
  localparam int N  = 13;
  localparam int CW = 7;
  localparam longint MOD = (64'd1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, in_valid = 1'b0, start = 1'b0;
  logic [CW-1:0] in_coef = '0;
  logic busy, done;
  logic [N-1:0] plain;

  int checks = 0;
  int errors = 0;
  int co [N];
  int wd = 0;
  logic m_busy = 1'b0, m_done = 1'b0;
  int m_cnt = 0;

  always #4ns clk = ~clk;

  ccn_unit #(.N(N), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .in_valid(in_valid), .in_coef(in_coef),
    .start(start), .busy(busy), .done(done), .plain(plain)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
    end else if (m_busy) begin
      m_cnt <= m_cnt + 1;
      if (m_cnt + 1 == 2*N) begin m_busy <= 1'b0; m_done <= 1'b1; end
    end else if (start && !sel) begin
      m_busy <= 1'b1; m_cnt <= 0; m_done <= 1'b0;
    end else if (sel && in_valid) begin
      m_done <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== m_busy) begin errors++; $display("FAIL R3 busy actual %0b expected %0b", busy, m_busy); end
      checks++;
      if (done !== m_done) begin errors++; $display("FAIL R6 done actual %0b expected %0b", done, m_done); end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL R3 watchdog expired actual busy=%0b expected run to finish", busy);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      sel = 1'b1; in_valid = 1'b1; in_coef = CW'(co[i]);
      tick();
    end
    sel = 1'b0; in_valid = 1'b0; in_coef = '0;
  endtask

  task automatic run_and_wait();
    start = 1'b1; tick(); start = 1'b0;
    for (int k = 0; k < 4*N && !m_done; k++) tick();
    @(negedge clk);
  endtask

  function automatic longint residue();
    longint v = 0;
    for (int i = 0; i < N; i++) v += longint'(co[i]) << i;
    return v % MOD;
  endfunction

  task automatic check_res(string req);
    longint exp_r = residue();
    longint act_r = longint'(plain) % MOD;
    checks++;
    if (act_r != exp_r) begin
      errors++;
      $display("FAIL %s residue actual %0d expected %0d", req, act_r, exp_r);
    end
  endtask

  task automatic check_exact(string req, logic [N-1:0] exp_v);
    checks++;
    if (plain !== exp_v) begin
      errors++;
      $display("FAIL %s plain actual %0h expected %0h", req, plain, exp_v);
    end
  endtask

  initial begin
    logic [N-1:0] bits;
    repeat (3) tick();
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || plain !== '0) begin
      errors++;
      $display("FAIL R1 reset actual busy=%0b done=%0b plain=%0h expected 0 0 0", busy, done, plain);
    end
    rst_n = 1'b1;
    tick();

    // R2 R4: random inputs
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < N; i++) co[i] = int'($urandom % 64);
      load_all(); run_and_wait(); check_res("R4");
      tick();
    end

    // R5: binary pass-through
    bits = '0;
    for (int i = 0; i < N; i++) begin co[i] = int'($urandom % 2); bits[i] = co[i][0]; end
    load_all(); run_and_wait(); check_exact("R5", bits); tick();

    // R7: all maximum
    for (int i = 0; i < N; i++) co[i] = 63;
    load_all(); run_and_wait(); check_res("R7"); tick();

    // R8: wrap of top carry
    for (int i = 0; i < N; i++) co[i] = 0;
    co[N-1] = 2;
    load_all(); run_and_wait(); check_exact("R8", N'(1)); tick();

    // R10: leftover carry after second turn
    for (int i = 0; i < N; i++) co[i] = 1;
    co[N-1] = 3;
    load_all(); run_and_wait(); check_exact("R10", N'(1)); tick();

    // R6: loads and starts during a run ignored, done held
    for (int i = 0; i < N; i++) co[i] = int'($urandom % 64);
    load_all();
    start = 1'b1; tick(); start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      sel = 1'b1; in_valid = 1'b1; in_coef = 7'h7f; start = 1'b1; tick();
      sel = 1'b0; start = 1'b1; tick();
    end
    sel = 1'b0; in_valid = 1'b0; start = 1'b0; in_coef = '0;
    for (int k = 0; k < 4*N && !m_done; k++) tick();
    @(negedge clk);
    check_res("R6");
    repeat (4) tick();
    @(negedge clk);
    checks++;
    if (done !== 1'b1) begin errors++; $display("FAIL R6 done hold actual %0b expected 1", done); end

    // R9: idle start with sel=1 and in_valid with sel=0 ignored
    for (int i = 0; i < N; i++) co[i] = int'($urandom % 64);
    load_all();
    sel = 1'b1; in_valid = 1'b0; start = 1'b1; tick();
    sel = 1'b0; start = 1'b0;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin errors++; $display("FAIL R9 busy actual %0b expected 0", busy); end
    tick();
    for (int k = 0; k < 4; k++) begin in_valid = 1'b1; in_coef = CW'(k + 40); tick(); end
    in_valid = 1'b0; in_coef = '0;
    run_and_wait(); check_res("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule